// File: doc/BRIEF.md
# PCI Initiator Termination Classifier

This block sits beside the initiator side of a PCI bus port and watches one transaction at a time that the local initiator has started. It samples the active-low framing, ready, select and stop lines on each rising clock edge. It times how long the bus takes to claim the cycle and decides how the transaction ended. Each ending produces a single-cycle strobe with a 3-bit reason code and the number of data phases that actually moved data.

The same block also owns the turnaround of the two initiator-driven sustained tri-state lines. While the initiator holds the bus it drives them. When the bus goes idle it drives them high for exactly one more cycle and then releases them. It also flags an initiator that drops its ready line before the current data phase has finished.

Top module: `pciTermClassifier`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `statusValid` low, `statusCode` 0, `phaseCount` 0, `irdyViolation` low, both output enables low and both driven values high.
- R2: The edge that first samples `frameN` low from idle is edge 0. If `devselN` is still high and `stopN` is high at edge 5, the transaction ends as a master abort (code 6). A claim seen at any edge from 1 to 5 avoids the abort.
- R3: `stopN`, `trdyN`, `devselN` and `irdyN` all sampled low end the transaction as a disconnect with data (code 2). That final transfer is included in the count.
- R4: `stopN` and `devselN` low with `trdyN` high, after at least one data phase has completed, end the transaction as a disconnect without data (code 3).
- R5: The same condition as R4 ends the transaction as a retry (code 4) when no data phase has yet completed.
- R6: `stopN` low while `devselN` is high ends the transaction as a target abort (code 5). This applies during the claim window as well.
- R7: A data phase that completes (`irdyN` and `trdyN` low) without `stopN`, with `frameN` already high, ends the transaction as a normal completion (code 1).
- R8: `phaseCount` increments on every edge that samples `irdyN` and `trdyN` both low inside a transaction. It is cleared at edge 0 of each new transaction and holds the final value while the status is shown.
- R9: `statusValid` is high for exactly one cycle, the cycle after the deciding edge, with `statusCode` holding the code. At all other times `statusCode` is 0. The codes are 0 none, 1 normal, 2 disconnect with data, 3 disconnect without data, 4 retry, 5 target abort and 6 master abort.
- R10: If `irdyN` was sampled low in a data phase that did not complete or terminate, and the next edge samples it high, `irdyViolation` is high for one cycle.
- R11: Each output enable is high in the cycle after any edge that sampled `frameN` or `irdyN` low, and in the cycle after that. The driven value follows the sampled line and is high while the enable is low. So after the bus goes idle the lines are driven high for exactly one cycle and then released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frameN | input | 1 | Framing line, active low |
| irdyN | input | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| devselN | input | 1 | Target claim, active low |
| stopN | input | 1 | Target stop request, active low |
| statusValid | output | 1 | One-cycle strobe marking a termination |
| statusCode | output | 3 | Termination reason code |
| phaseCount | output | CNT_W | Completed data phases in the current transaction |
| irdyViolation | output | 1 | One-cycle flag for initiator ready dropped early |
| frameOut | output | 1 | Value driven on the framing line |
| frameOe | output | 1 | Output enable for the framing line |
| irdyOut | output | 1 | Value driven on the initiator ready line |
| irdyOe | output | 1 | Output enable for the initiator ready line |

## Verification
A wrong claim-window counter shows up as a master-abort strobe one edge early or late, or as a strobe missing where a late claim should have been accepted. A stale data-moved flag turns a retry into a disconnect without data, or the reverse, at the very strobe that ends the transaction. A counter that is not cleared shows a nonzero `phaseCount` in the cycle right after the address edge. Enable state that is held too long or too short is visible within two cycles of the bus going idle.

// File: rtl/pciTermPkg.sv
package pciTermPkg;

  typedef enum logic [2:0] {
    TERM_NONE       = 3'd0,
    TERM_NORMAL     = 3'd1,
    TERM_DISC_DATA  = 3'd2,
    TERM_DISC_EMPTY = 3'd3,
    TERM_RETRY      = 3'd4,
    TERM_TABORT     = 3'd5,
    TERM_MABORT     = 3'd6
  } termCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      clearCount;
    logic      incCount;
    logic      report;
    termCode_e code;
    logic      irdyDrop;
  } ctrlStrobes_t;

endpackage

// File: rtl/pciTermCtrl.sv
module pciTermCtrl
  import pciTermPkg::*;
#(
  parameter int CLAIM_LIMIT = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frameN,
  input  logic         irdyN,
  input  logic         trdyN,
  input  logic         devselN,
  input  logic         stopN,
  output ctrlStrobes_t strobes
);

  localparam int WAIT_W = $clog2(CLAIM_LIMIT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CLAIM, ST_DATA, ST_DRAIN} state_e;

  state_e            state, stateNext;
  logic [WAIT_W-1:0] waitCnt, waitCntNext;
  logic              moved, movedNext;
  logic              irdyHeld, irdyHeldNext;

  logic phaseDone;
  logic inTxn;
  logic finish;

  assign phaseDone = !irdyN && !trdyN;
  assign inTxn     = (state == ST_CLAIM) || (state == ST_DATA);

  always_comb begin
    strobes     = '0;
    stateNext   = state;
    waitCntNext = waitCnt;
    movedNext   = moved;
    finish      = 1'b0;

    unique case (state)
      ST_IDLE: begin
        if (!frameN) begin
          strobes.clearCount = 1'b1;
          movedNext          = 1'b0;
          waitCntNext        = WAIT_W'(1);
          stateNext          = ST_CLAIM;
        end
      end
      ST_CLAIM, ST_DATA: begin
        if (!stopN && devselN) begin
          finish       = 1'b1;
          strobes.code = TERM_TABORT;
        end else if (!stopN) begin
          if (trdyN) begin
            finish       = 1'b1;
            strobes.code = moved ? TERM_DISC_EMPTY : TERM_RETRY;
          end else if (!irdyN) begin
            finish           = 1'b1;
            strobes.incCount = 1'b1;
            strobes.code     = TERM_DISC_DATA;
          end else begin
            stateNext = ST_DATA;
          end
        end else if ((state == ST_CLAIM) && devselN) begin
          if (waitCnt == WAIT_W'(CLAIM_LIMIT)) begin
            finish       = 1'b1;
            strobes.code = TERM_MABORT;
          end else begin
            waitCntNext = waitCnt + WAIT_W'(1);
          end
        end else begin
          stateNext = ST_DATA;
          if (phaseDone) begin
            strobes.incCount = 1'b1;
            movedNext        = 1'b1;
            if (frameN) begin
              finish       = 1'b1;
              strobes.code = TERM_NORMAL;
            end
          end
        end
        if (finish) begin
          strobes.report = 1'b1;
          stateNext      = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (frameN && irdyN) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase

    strobes.irdyDrop = inTxn && irdyHeld && irdyN;
    irdyHeldNext     = inTxn && !irdyN && !phaseDone && !finish;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      moved    <= 1'b0;
      irdyHeld <= 1'b0;
    end else begin
      state    <= stateNext;
      waitCnt  <= waitCntNext;
      moved    <= movedNext;
      irdyHeld <= irdyHeldNext;
    end
  end

endmodule

// File: rtl/pciTermDatapath.sv
module pciTermDatapath
  import pciTermPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frameN,
  input  logic             irdyN,
  input  ctrlStrobes_t     strobes,
  output logic             statusValid,
  output logic [2:0]       statusCode,
  output logic [CNT_W-1:0] phaseCount,
  output logic             irdyViolation,
  output logic             frameOut,
  output logic             frameOe,
  output logic             irdyOut,
  output logic             irdyOe
);

  logic ownBus;
  logic ownBusD;

  assign ownBus = !frameN || !irdyN;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCount <= '0;
    end else if (strobes.clearCount) begin
      phaseCount <= '0;
    end else if (strobes.incCount) begin
      phaseCount <= phaseCount + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusValid   <= 1'b0;
      statusCode    <= 3'd0;
      irdyViolation <= 1'b0;
    end else begin
      statusValid   <= strobes.report;
      statusCode    <= strobes.report ? strobes.code : 3'd0;
      irdyViolation <= strobes.irdyDrop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ownBusD  <= 1'b0;
      frameOe  <= 1'b0;
      irdyOe   <= 1'b0;
      frameOut <= 1'b1;
      irdyOut  <= 1'b1;
    end else begin
      ownBusD  <= ownBus;
      frameOe  <= ownBus || ownBusD;
      irdyOe   <= ownBus || ownBusD;
      frameOut <= frameN;
      irdyOut  <= irdyN;
    end
  end

endmodule

// File: rtl/pciTermClassifier.sv
module pciTermClassifier
  import pciTermPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int CLAIM_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic             trdyN,
  input  logic             devselN,
  input  logic             stopN,
  output logic             statusValid,
  output logic [2:0]       statusCode,
  output logic [CNT_W-1:0] phaseCount,
  output logic             irdyViolation,
  output logic             frameOut,
  output logic             frameOe,
  output logic             irdyOut,
  output logic             irdyOe
);

  ctrlStrobes_t strobes;

  pciTermCtrl #(.CLAIM_LIMIT(CLAIM_LIMIT)) ctrl (
    .clk     (clk),
    .rst     (rst),
    .frameN  (frameN),
    .irdyN   (irdyN),
    .trdyN   (trdyN),
    .devselN (devselN),
    .stopN   (stopN),
    .strobes (strobes)
  );

  pciTermDatapath #(.CNT_W(CNT_W)) dpath (
    .clk           (clk),
    .rst           (rst),
    .frameN        (frameN),
    .irdyN         (irdyN),
    .strobes       (strobes),
    .statusValid   (statusValid),
    .statusCode    (statusCode),
    .phaseCount    (phaseCount),
    .irdyViolation (irdyViolation),
    .frameOut      (frameOut),
    .frameOe       (frameOe),
    .irdyOut       (irdyOut),
    .irdyOe        (irdyOe)
  );

endmodule

// File: rtl/pciTermCheck.sv
module pciTermCheck #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             statusValid,
  input logic [2:0]       statusCode,
  input logic [CNT_W-1:0] phaseCount,
  input logic             irdyViolation,
  input logic             frameOut,
  input logic             frameOe,
  input logic             irdyOut,
  input logic             irdyOe
);

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!statusValid && !frameOe && !irdyOe && phaseCount == '0));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    statusValid |=> !statusValid);

  assert_code_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !statusValid |-> statusCode == 3'd0);

  assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
    statusValid |-> (statusCode >= 3'd1 && statusCode <= 3'd6));

  assert_retry_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (statusValid && statusCode == 3'd4) |-> phaseCount == '0);

  assert_nodata_after_R4: assert property (@(posedge clk) disable iff (rst)
    (statusValid && statusCode == 3'd3) |-> phaseCount != '0);

  assert_violation_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    irdyViolation |=> !irdyViolation);

  assert_release_high_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(frameOe) |-> ($past(frameOut) && $past(irdyOut)));

  assert_parked_high_R11: assert property (@(posedge clk) disable iff (rst)
    (!frameOe |-> frameOut) and (!irdyOe |-> irdyOut));

endmodule

bind pciTermClassifier pciTermCheck #(.CNT_W(CNT_W)) chk (
  .clk           (clk),
  .rst           (rst),
  .statusValid   (statusValid),
  .statusCode    (statusCode),
  .phaseCount    (phaseCount),
  .irdyViolation (irdyViolation),
  .frameOut      (frameOut),
  .frameOe       (frameOe),
  .irdyOut       (irdyOut),
  .irdyOe        (irdyOe)
);

// File: tb/tb_pciTermClassifier.sv
module tb_pciTermClassifier;

  localparam int CNT_W = 16;
  localparam int LIMIT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameN = 1'b1, irdyN = 1'b1, trdyN = 1'b1, devselN = 1'b1, stopN = 1'b1;
  logic             statusValid, irdyViolation;
  logic [2:0]       statusCode;
  logic [CNT_W-1:0] phaseCount;
  logic             frameOut, frameOe, irdyOut, irdyOe;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int viols  = 0;
  int gotCode = 0;
  int gotCount = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pciTermClassifier #(.CNT_W(CNT_W), .CLAIM_LIMIT(LIMIT)) dut (
    .clk(clk), .rst(rst), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .devselN(devselN), .stopN(stopN), .statusValid(statusValid),
    .statusCode(statusCode), .phaseCount(phaseCount),
    .irdyViolation(irdyViolation), .frameOut(frameOut), .frameOe(frameOe),
    .irdyOut(irdyOut), .irdyOe(irdyOe)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (statusValid) begin
        pulses   = pulses + 1;
        gotCode  = int'(statusCode);
        gotCount = int'(phaseCount);
      end
      if (irdyViolation) viols = viols + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic i, input logic t, input logic d, input logic s);
    frameN = f; irdyN = i; trdyN = t; devselN = d; stopN = s;
    @(negedge clk);
  endtask

  // term: 0 normal, 1 disconnect with data, 2 stop without trdy, 3 target abort
  task automatic runTxn(input int dly, input int nph, input int term);
    int expCode;
    int expCount;
    pulses = 0;
    viols  = 0;
    drive(0, 1, 1, 1, 1);
    check(phaseCount == 0, "R8 clear at address", int'(phaseCount), 0);
    for (int w = 1; w < dly; w++) drive(0, 0, 1, 1, 1);
    if (dly <= LIMIT) begin
      for (int p = 0; p < nph; p++) begin
        if (p == nph - 1 && term == 0)      drive(1, 0, 0, 0, 1);
        else if (p == nph - 1 && term == 1) drive(0, 0, 0, 0, 0);
        else                                drive(0, 0, 0, 0, 1);
      end
      if (term == 2) drive(0, 0, 1, 0, 0);
      if (term == 3) drive(0, 0, 1, 1, 0);
    end
    drive(1, 0, 1, 1, 1);
    drive(1, 1, 1, 1, 1);
    drive(1, 1, 1, 1, 1);
    if (dly > LIMIT)      begin expCode = 6; expCount = 0; end
    else if (term == 0)   begin expCode = 1; expCount = nph; end
    else if (term == 1)   begin expCode = 2; expCount = nph; end
    else if (term == 2)   begin expCode = (nph == 0) ? 4 : 3; expCount = nph; end
    else                  begin expCode = 5; expCount = nph; end
    check(pulses == 1, "R9 single strobe", pulses, 1);
    case (expCode)
      1: check(gotCode == expCode, "R7 normal code", gotCode, expCode);
      2: check(gotCode == expCode, "R3 disconnect-with-data code", gotCode, expCode);
      3: check(gotCode == expCode, "R4 disconnect-without-data code", gotCode, expCode);
      4: check(gotCode == expCode, "R5 retry code", gotCode, expCode);
      5: check(gotCode == expCode, "R6 target abort code", gotCode, expCode);
      default: check(gotCode == expCode, "R2 master abort code", gotCode, expCode);
    endcase
    check(gotCount == expCount, "R8 phase count at strobe", gotCount, expCount);
    check(viols == 0, "R10 no false violation", viols, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!statusValid && statusCode == 0, "R1 status idle", int'(statusValid), 0);
    check(phaseCount == 0, "R1 count zero", int'(phaseCount), 0);
    check(!frameOe && !irdyOe && frameOut && irdyOut, "R1 lines released",
          int'({frameOe, irdyOe, frameOut, irdyOut}), 3);
    check(!irdyViolation, "R1 no violation", int'(irdyViolation), 0);
    rst = 1'b0;
    drive(1, 1, 1, 1, 1);

    // sweep of claim delay, phase count and ending (R2..R8)
    for (int dly = 1; dly <= LIMIT + 1; dly++)
      for (int term = 0; term < 4; term++)
        for (int nph = 0; nph < 4; nph++) begin
          if (term < 2 && nph == 0) continue;
          if (dly > LIMIT && nph > 0) continue;
          runTxn(dly, nph, term);
        end

    // R11 turnaround after a one-phase normal transaction
    drive(0, 1, 1, 1, 1);
    check(frameOe && !frameOut, "R11 driving during address", int'(frameOe), 1);
    drive(1, 0, 0, 0, 1);
    check(frameOe && irdyOe && frameOut && !irdyOut, "R11 driving in data phase",
          int'({frameOe, irdyOe, frameOut, irdyOut}), 14);
    drive(1, 1, 1, 1, 1);
    check(frameOe && irdyOe && frameOut && irdyOut, "R11 one driven-high cycle",
          int'({frameOe, irdyOe, frameOut, irdyOut}), 15);
    drive(1, 1, 1, 1, 1);
    check(!frameOe && !irdyOe, "R11 released", int'({frameOe, irdyOe}), 0);

    // R10 ready dropped mid-phase
    viols = 0;
    drive(0, 1, 1, 1, 1);
    drive(0, 0, 1, 0, 1);
    check(!irdyViolation, "R10 no flag while waiting", int'(irdyViolation), 0);
    drive(0, 1, 1, 0, 1);
    check(irdyViolation, "R10 flag after drop", int'(irdyViolation), 1);
    drive(1, 0, 0, 0, 1);
    check(!irdyViolation && viols == 1, "R10 single-cycle flag", viols, 1);
    drive(1, 1, 1, 1, 1);
    drive(1, 1, 1, 1, 1);

    // R8 counter restarts after a multi-phase transaction
    runTxn(2, 3, 0);
    runTxn(1, 0, 2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule